// File: doc/BRIEF.md
# Flash Program/Erase Status-Polling Controller

This block sits on the host side of a parallel NOR-style flash bus. When started, it issues the unlock-and-command write sequence for a byte program, a sector erase or a whole-chip erase. It then reads the status byte at the target address, one read per cycle, until the operation finishes or has to be reported as failed. The host supplies the operation, the address and the data with a one-cycle start request. It gets back a busy level and a one-cycle done or error pulse.

Completion is judged from the data-polling bit, bit 7. This bit returns the complement of the written bit, or 0 during an erase, while the flash is working. It returns the true value once the flash has finished. Near the end, that bit can settle before the other seven bits do. For this reason, a matching read is always followed by one more read before the result is reported, and for a program that second read is compared in full against the written byte. Bit 5 is the flash's time-limit flag. When it is seen, the controller takes one more look before it declares a failure. A poll budget bounds the wait if neither condition ever appears.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A start request accepted while idle (op 2'b00 = program) produces, on the very next cycle and then one per cycle, four write strobes with address/data 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the target address with the write data.
- R2: For op 2'b01 (sector erase) and 2'b10 or 2'b11 (chip erase), six write strobes are issued one per cycle: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55. The sixth is target address/0x30 for a sector erase and 0x555/0x10 for a chip erase.
- R3: No read strobe occurs before the last write strobe of the sequence. Write and read strobes are never active together. Every status read uses the target address latched at start.
- R4: A read counts as a completion match when bit 7 equals bit 7 of the write data (program) or when bit 7 is 1 (erase). Until a match is seen, polling continues at one read per cycle.
- R5: After a match, exactly one more read is made. For a program, done is reported if all 8 bits equal the write data, and error otherwise. For an erase, done is reported.
- R6: A non-matching poll read with bit 5 set triggers one recheck read. A match on that read leads to the confirming read of R5. No match on that read reports error.
- R7: If MAX_POLLS poll reads pass with neither a match nor bit 5 set, error is reported, after exactly MAX_POLLS reads.
- R8: done and error are single-cycle pulses, never together, issued in the cycle busy falls. A start request while busy is ignored.
- R9: Out of reset, busy, done, error and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| op_i | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| addr_i | input | ADDR_W | Target / polling address |
| wdata_i | input | DATA_W | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Successful completion pulse |
| error_o | output | 1 | Failure pulse |
| fl_addr_o | output | ADDR_W | Flash bus address |
| fl_wdata_o | output | DATA_W | Flash bus write data |
| fl_we_o | output | 1 | Write strobe, one cycle per pulse |
| fl_oe_o | output | 1 | Read strobe, one cycle per read |
| fl_rdata_i | input | DATA_W | Flash bus read data, sampled during a read strobe |

## Verification
The bench builds the controller with a 12-bit address and a poll budget of six reads. This lets the budget-exhaustion path end after a handful of reads, and every unlock address fits the bus exactly. A behavioural flash model answers the reads with a toggling status byte for a chosen number of reads. It then returns one read in which bit 7 is already true but the low bits are still wrong, and after that the final byte. With this model, the confirming re-read, the bit-5 recovery and bit-5 failure paths, and a corrupted final byte can each be reached on purpose.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_RECHECK,
        ST_CONFIRM
    } poll_state_e;

    localparam logic [1:0] OP_PROGRAM = 2'b00;
    localparam logic [1:0] OP_SECTOR  = 2'b01;

    localparam int SEQ_IDX_W   = 3;
    localparam int PROG_LAST   = 3;
    localparam int ERASE_LAST  = 5;
    localparam int DONE_BIT    = 7;
    localparam int LIMIT_BIT   = 5;

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [1:0]           op_i,
    input  logic [SEQ_IDX_W-1:0] idx_i,
    input  logic [ADDR_W-1:0]    tgt_addr_i,
    input  logic [DATA_W-1:0]    tgt_data_i,
    output logic [ADDR_W-1:0]    bus_addr_o,
    output logic [DATA_W-1:0]    bus_data_o,
    output logic                 last_o
);
    localparam logic [ADDR_W-1:0] KEY_A1 = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] KEY_A2 = ADDR_W'(12'h2AA);

    always_comb begin
        bus_addr_o = KEY_A1;
        bus_data_o = '0;
        last_o     = 1'b0;
        if (op_i == OP_PROGRAM) begin
            last_o = (idx_i == SEQ_IDX_W'(PROG_LAST));
            case (idx_i)
                3'd0:    begin bus_addr_o = KEY_A1;     bus_data_o = DATA_W'(8'hAA); end
                3'd1:    begin bus_addr_o = KEY_A2;     bus_data_o = DATA_W'(8'h55); end
                3'd2:    begin bus_addr_o = KEY_A1;     bus_data_o = DATA_W'(8'hA0); end
                default: begin bus_addr_o = tgt_addr_i; bus_data_o = tgt_data_i;     end
            endcase
        end else begin
            last_o = (idx_i == SEQ_IDX_W'(ERASE_LAST));
            case (idx_i)
                3'd0, 3'd3: begin bus_addr_o = KEY_A1; bus_data_o = DATA_W'(8'hAA); end
                3'd1, 3'd4: begin bus_addr_o = KEY_A2; bus_data_o = DATA_W'(8'h55); end
                3'd2:       begin bus_addr_o = KEY_A1; bus_data_o = DATA_W'(8'h80); end
                default: begin
                    if (op_i == OP_SECTOR) begin
                        bus_addr_o = tgt_addr_i;
                        bus_data_o = DATA_W'(8'h30);
                    end else begin
                        bus_addr_o = KEY_A1;
                        bus_data_o = DATA_W'(8'h10);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval
    import flash_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              is_prog_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              match_o,
    output logic              limit_o,
    output logic              full_ok_o
);
    always_comb begin
        match_o   = is_prog_i ? (rdata_i[DONE_BIT] == wdata_i[DONE_BIT])
                              : rdata_i[DONE_BIT];
        limit_o   = rdata_i[LIMIT_BIT];
        full_ok_o = (rdata_i == wdata_i);
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int MAX_POLLS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [DATA_W-1:0] fl_wdata_o,
    output logic              fl_we_o,
    output logic              fl_oe_o,
    input  logic [DATA_W-1:0] fl_rdata_i
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

    typedef struct packed {
        poll_state_e          st;
        logic [SEQ_IDX_W-1:0] idx;
        logic [CNT_W-1:0]     cnt;
        logic [1:0]           op;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
        logic                 done;
        logic                 err;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_data;
    logic              seq_last;
    logic              is_prog;
    logic              st_match, st_limit, st_full_ok;

    assign is_prog = (ctrl_q.op == OP_PROGRAM);

    flash_cmd_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
        .op_i       (ctrl_q.op),
        .idx_i      (ctrl_q.idx),
        .tgt_addr_i (ctrl_q.addr),
        .tgt_data_i (ctrl_q.data),
        .bus_addr_o (seq_addr),
        .bus_data_o (seq_data),
        .last_o     (seq_last)
    );

    flash_status_eval #(.DATA_W(DATA_W)) u_eval (
        .is_prog_i (is_prog),
        .rdata_i   (fl_rdata_i),
        .wdata_i   (ctrl_q.data),
        .match_o   (st_match),
        .limit_o   (st_limit),
        .full_ok_o (st_full_ok)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        ctrl_d.err  = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.st   = ST_CMD;
                    ctrl_d.idx  = '0;
                    ctrl_d.cnt  = '0;
                    ctrl_d.op   = op_i;
                    ctrl_d.addr = addr_i;
                    ctrl_d.data = wdata_i;
                end
            end
            ST_CMD: begin
                if (seq_last) ctrl_d.st  = ST_POLL;
                else          ctrl_d.idx = ctrl_q.idx + 1'b1;
            end
            ST_POLL: begin
                if (st_match) begin
                    ctrl_d.st = ST_CONFIRM;
                end else if (st_limit) begin
                    ctrl_d.st = ST_RECHECK;
                end else if (ctrl_q.cnt == LAST_POLL) begin
                    ctrl_d.st  = ST_IDLE;
                    ctrl_d.err = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_RECHECK: begin
                if (st_match) begin
                    ctrl_d.st = ST_CONFIRM;
                end else begin
                    ctrl_d.st  = ST_IDLE;
                    ctrl_d.err = 1'b1;
                end
            end
            ST_CONFIRM: begin
                ctrl_d.st = ST_IDLE;
                if (is_prog && !st_full_ok) ctrl_d.err  = 1'b1;
                else                        ctrl_d.done = 1'b1;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            ctrl_q.st <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        fl_we_o    = (ctrl_q.st == ST_CMD);
        fl_oe_o    = (ctrl_q.st == ST_POLL) || (ctrl_q.st == ST_RECHECK)
                  || (ctrl_q.st == ST_CONFIRM);
        fl_addr_o  = fl_we_o ? seq_addr : ctrl_q.addr;
        fl_wdata_o = fl_we_o ? seq_data : '0;
        busy_o     = (ctrl_q.st != ST_IDLE);
        done_o     = ctrl_q.done;
        error_o    = ctrl_q.err;
    end
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
    parameter int ADDR_W    = 16,
    parameter int MAX_POLLS = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              error_o,
    input logic              fl_we_o,
    input logic              fl_oe_o,
    input logic [ADDR_W-1:0] fl_addr_o
);
    logic [ADDR_W-1:0] seen_addr;
    int unsigned       oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_addr <= '0;
            oe_run    <= 0;
        end else begin
            if (start_i && !busy_o) seen_addr <= addr_i;
            if (fl_we_o)      oe_run <= 0;
            else if (fl_oe_o) oe_run <= oe_run + 1;
        end
    end

    assert_start_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (fl_we_o && busy_o));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_oe_o));

    assert_poll_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_oe_o |-> (fl_addr_o == seen_addr));

    assert_read_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_run <= MAX_POLLS + 2);

    assert_outcome_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    assert_outcome_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |-> !busy_o);

    assert_outcome_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |=> !(done_o || error_o));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(fl_we_o || fl_oe_o));
endmodule

bind flash_poll_ctrl flash_poll_chk #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .error_o   (error_o),
    .fl_we_o   (fl_we_o),
    .fl_oe_o   (fl_oe_o),
    .fl_addr_o (fl_addr_o)
);

// File: tb/tb_flash_poll_ctrl.sv
`timescale 1ns/1ps
module tb_flash_poll_ctrl;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int MAXP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          busy, done, error, we, oe;
    logic [AW-1:0] fa;
    logic [DW-1:0] fwd;
    logic [DW-1:0] frd;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    flash_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
        .wdata_i(wdata), .busy_o(busy), .done_o(done), .error_o(error),
        .fl_addr_o(fa), .fl_wdata_o(fwd), .fl_we_o(we), .fl_oe_o(oe),
        .fl_rdata_i(frd)
    );

    // flash model controls
    logic          m_prog = 1'b1;
    logic [DW-1:0] m_wd = '0;
    int            m_busy = 0;
    int            m_t5 = -1;
    logic [DW-1:0] m_final = '0;
    logic          clr = 1'b0;
    logic [AW-1:0] exp_poll = '0;
    int            exp_we = 0;

    int            we_cnt, rd_cnt, oe_cnt, bad_addr, early_rd;
    logic [AW-1:0] cap_a [8];
    logic [DW-1:0] cap_d [8];

    always @(posedge clk) begin
        if (clr) begin
            we_cnt <= 0; rd_cnt <= 0; oe_cnt <= 0; bad_addr <= 0; early_rd <= 0;
        end else begin
            if (we) begin
                if (we_cnt < 8) begin
                    cap_a[we_cnt] <= fa;
                    cap_d[we_cnt] <= fwd;
                end
                we_cnt <= we_cnt + 1;
                rd_cnt <= 0;
            end
            if (oe) begin
                rd_cnt <= rd_cnt + 1;
                oe_cnt <= oe_cnt + 1;
                if (fa != exp_poll) bad_addr <= bad_addr + 1;
                if (we_cnt != exp_we || we) early_rd <= early_rd + 1;
            end
        end
    end

    always_comb begin
        if (rd_cnt < m_busy)
            frd = {(m_prog ? ~m_wd[7] : 1'b0), rd_cnt[0],
                   (m_t5 >= 0 && rd_cnt >= m_t5), 5'h0A};
        else if (rd_cnt == m_busy)
            frd = {m_final[7], ~m_final[6:0]};
        else
            frd = m_final;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int busy_len, input int t5,
                          input logic [DW-1:0] fin, input logic exp_err,
                          input int exp_oe, input string req, input logic intrude);
        logic [AW-1:0] ea [6];
        logic [DW-1:0] ed [6];
        int n;
        logic got_done, got_err, seen;
        n = (o == 2'b00) ? 4 : 6;
        ea[0] = 12'h555; ed[0] = 8'hAA;
        ea[1] = 12'h2AA; ed[1] = 8'h55;
        if (o == 2'b00) begin
            ea[2] = 12'h555; ed[2] = 8'hA0;
            ea[3] = a;       ed[3] = d;
        end else begin
            ea[2] = 12'h555; ed[2] = 8'h80;
            ea[3] = 12'h555; ed[3] = 8'hAA;
            ea[4] = 12'h2AA; ed[4] = 8'h55;
            if (o == 2'b01) begin ea[5] = a;       ed[5] = 8'h30; end
            else            begin ea[5] = 12'h555; ed[5] = 8'h10; end
        end
        m_prog = (o == 2'b00); m_wd = d; m_busy = busy_len; m_t5 = t5; m_final = fin;
        exp_poll = a; exp_we = n;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        start = 1'b1; op = o; addr = a; wdata = d;
        @(negedge clk); start = 1'b0; addr = ~a;
        chk(we && busy, "R1", "write strobe cycle after start", int'(we), 1);
        seen = 1'b0; got_done = 1'b0; got_err = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done || error) begin
                seen = 1'b1; got_done = done; got_err = error;
                break;
            end
            start = (intrude && i == 6);
            if (intrude && i == 6) begin op = 2'b10; addr = 12'h0F0; end
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen, req, "outcome seen", int'(seen), 1);
        chk(got_err == exp_err && got_done == !exp_err, req, "error outcome",
            int'(got_err), int'(exp_err));
        chk(!busy, "R8", "busy low with outcome", int'(busy), 0);
        chk(oe_cnt == exp_oe, req, "read count", oe_cnt, exp_oe);
        chk(we_cnt == n, (n == 4) ? "R1" : "R2", "write pulse count", we_cnt, n);
        for (int k = 0; k < n; k++) begin
            chk(cap_a[k] == ea[k], (n == 4) ? "R1" : "R2", "cmd address",
                int'(cap_a[k]), int'(ea[k]));
            chk(cap_d[k] == ed[k], (n == 4) ? "R1" : "R2", "cmd data",
                int'(cap_d[k]), int'(ed[k]));
        end
        chk(bad_addr == 0, "R3", "poll reads at wrong address", bad_addr, 0);
        chk(early_rd == 0, "R3", "reads before last write", early_rd, 0);
        @(negedge clk);
        chk(!done && !error, "R8", "outcome pulse width", int'(done | error), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !error && !we && !oe, "R9", "idle outputs after reset",
            int'({busy, done, error, we, oe}), 0);
    endtask

    task automatic t_program_ok();      // R4 R5: 3 busy, transitional, confirm
        run_op(2'b00, 12'h123, 8'hC3, 3, -1, 8'hC3, 1'b0, 5, "R4", 1'b0);
        run_op(2'b00, 12'h7FE, 8'h35, 2, -1, 8'h35, 1'b0, 4, "R4", 1'b0);
    endtask

    task automatic t_program_bad();     // R5 confirm mismatch on low bits
        run_op(2'b00, 12'h040, 8'hA5, 1, -1, 8'hA4, 1'b1, 3, "R5", 1'b0);
    endtask

    task automatic t_erase();           // R2 R4 R5
        run_op(2'b01, 12'h800, 8'h00, 2, -1, 8'hFF, 1'b0, 4, "R4", 1'b0);
        run_op(2'b10, 12'h321, 8'h00, 0, -1, 8'hFF, 1'b0, 2, "R5", 1'b0);
        run_op(2'b11, 12'h004, 8'h00, 1, -1, 8'hFF, 1'b0, 3, "R2", 1'b0);
    endtask

    task automatic t_limit_recover();   // R6 recheck matches
        run_op(2'b00, 12'h0AA, 8'h81, 3, 2, 8'h81, 1'b0, 5, "R6", 1'b0);
    endtask

    task automatic t_limit_fail();      // R6 recheck does not match
        run_op(2'b01, 12'h900, 8'h00, 100, 1, 8'hFF, 1'b1, 3, "R6", 1'b0);
    endtask

    task automatic t_budget();          // R7 exactly MAXP reads then error
        run_op(2'b00, 12'h111, 8'h5A, 100, -1, 8'h5A, 1'b1, MAXP, "R7", 1'b0);
    endtask

    task automatic t_start_busy();      // R8 start while busy ignored
        run_op(2'b00, 12'h456, 8'h9C, 4, -1, 8'h9C, 1'b0, 6, "R8", 1'b1);
        repeat (3) @(negedge clk);
        chk(!busy && !we && !oe, "R8", "no operation from ignored start",
            int'({busy, we, oe}), 0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clr = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_ok();
        t_program_bad();
        t_erase();
        t_limit_recover();
        t_limit_fail();
        t_budget();
        t_start_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule